// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a free-running watchdog counter controlled by one 8-bit control and status register. Two enable bits choose one of four operating modes: stopped, interrupt only, reset only, or combined, where a time-out first raises an interrupt and the next one resets the system. Software keeps the watchdog from firing by pulsing the restart input. A 4-bit prescaler select sets the time-out length in powers of two.

In combined mode the first time-out only sets the interrupt flag. When the CPU acknowledges that interrupt, hardware clears both the flag and the interrupt-enable bit. This moves the block into reset mode, so the next time-out resets the system unless software sets the interrupt enable again. A time-out in combined mode while the flag is still pending also resets the system.

The mode controller has four states, named after the enable bits {interrupt enable, reset enable}.

- MODE_OFF (00): counter held at zero, no requests.
- MODE_INT (10): time-out sets the flag.
- MODE_RST (01): time-out pulses the reset request.
- MODE_BOTH (11): time-out sets the flag, or pulses reset if the flag is already set.

The transitions are:

- WRITE: any state to the state given by written bits 6 and 3. It has priority.
- ACK_DEMOTE: MODE_BOTH to MODE_RST on an interrupt acknowledge.
- HOLD: no change otherwise.

Top module: `wdog_ctl`

## Requirements
- R1: Register layout, bit 7 down to 0: interrupt flag, interrupt enable, select bit 3, change-enable (plain read/write storage), reset enable, select bits 2..0. After reset every bit reads 0 except reset enable, which takes parameter RST_ENA_INIT.
- R2: Time-out length is 2^(BASE_LOG2+N) clock cycles, where N is the 4-bit select. Codes above 9 act as 9. The count starts from zero when the counter leaves the held state.
- R3: In interrupt mode (enable bits 6=1, 3=0) a time-out sets the flag and never asserts sys_rst_o.
- R4: irq_o is high only while the flag, the interrupt enable and gie_i are all high.
- R5: In reset mode (bit 6=0, bit 3=1) a time-out asserts sys_rst_o for exactly one cycle, one cycle after the final count.
- R6: In combined mode the first time-out sets the flag without a reset. A time-out while the flag is still set asserts sys_rst_o and leaves the flag set.
- R7: ack_i clears the flag. In combined mode it also clears the interrupt enable, so the next time-out asserts sys_rst_o.
- R8: A register write with bit 7 = 1 clears the flag. A write with bit 7 = 0 leaves the flag unchanged. A time-out that sets the flag wins over a clear in the same cycle.
- R9: A kick_i pulse restarts the count from zero and leaves the register contents unchanged.
- R10: With both enables clear, the counter is held at zero and no flag or reset request is raised.
- R11: Writing the interrupt enable back to 1 after an acknowledge keeps combined mode, so the next time-out sets the flag instead of resetting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one counter tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Restart pulse; clears the counter |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | One-cycle system reset request |
| rd_data_o | output | 8 | Register read data |

## Verification
The assertions check the following on every cycle:

- the interrupt request never rises without the global enable;
- the reset request never lasts more than one cycle;
- interrupt-only mode, stopped mode and a kick never lead to a reset request;
- an acknowledge in combined mode always drops the interrupt enable while keeping reset enable.

Only the directed scenarios can show the following:

- exact time-out lengths per select code, including clamping;
- the two-step progression from flag to reset in combined mode;
- re-arming after an acknowledge;
- the write-one-to-clear behaviour of the flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Mode encoding is {interrupt enable, reset enable}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RST  = 2'b01,
        MODE_INT  = 2'b10,
        MODE_BOTH = 2'b11
    } wdog_mode_e;

    localparam int REG_W    = 8;
    localparam int SEL_W    = 4;
    localparam int MAX_EXP  = 9;
    localparam int BIT_FLAG = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_SEL3 = 5;
    localparam int BIT_CE   = 4;
    localparam int BIT_RE   = 3;

    function automatic wdog_mode_e mode_from(input logic ie, input logic re);
        return wdog_mode_e'({ie, re});
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             kick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tmo_o
);
    localparam int CW  = BASE_LOG2 + MAX_EXP;
    localparam int SHW = $clog2(CW + 1) + 1;

    logic [CW-1:0]    cnt_q;
    logic [SEL_W-1:0] eff_sel;
    logic [CW-1:0]    last_cnt;

    always_comb begin
        eff_sel  = (sel_i > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : sel_i;
        // When the shift equals CW the one falls off and the subtraction yields all ones.
        last_cnt = (CW'(1) << (SHW'(BASE_LOG2) + SHW'(eff_sel))) - CW'(1);
        tmo_o    = run_i && !kick_i && (cnt_q >= last_cnt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || kick_i || tmo_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter bit RST_ENA_INIT = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic       wr_ie_i,
    input  logic       wr_re_i,
    input  logic       ack_i,
    input  logic       tmo_i,
    input  logic       flag_i,
    output wdog_mode_e state_o,
    output logic       set_flag_o,
    output logic       sys_rst_o
);
    wdog_mode_e state_q, state_d;
    logic       rst_req;
    logic       sys_rst_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF:  state_d = MODE_OFF;
            MODE_INT:  state_d = MODE_INT;
            MODE_RST:  state_d = MODE_RST;
            MODE_BOTH: if (ack_i) state_d = MODE_RST;   // ACK_DEMOTE
        endcase
        if (wr_en_i) begin
            state_d = mode_from(wr_ie_i, wr_re_i);     // WRITE
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RST_ENA_INIT ? MODE_RST : MODE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        set_flag_o = 1'b0;
        rst_req    = 1'b0;
        unique case (state_q)
            MODE_OFF:  ;
            MODE_INT:  set_flag_o = tmo_i;
            MODE_RST:  rst_req    = tmo_i;
            MODE_BOTH: begin
                if (flag_i) rst_req    = tmo_i;
                else        set_flag_o = tmo_i;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sys_rst_q <= 1'b0;
        else         sys_rst_q <= rst_req;
    end

    assign state_o   = state_q;
    assign sys_rst_o = sys_rst_q;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             ack_i,
    input  logic             set_flag_i,
    output logic             flag_o,
    output logic             ce_o,
    output logic [SEL_W-1:0] sel_o
);
    logic             flag_q;
    logic             ce_q;
    logic [SEL_W-1:0] sel_q;
    logic             clr_flag;

    assign clr_flag = ack_i || (wr_en_i && wr_data_i[BIT_FLAG]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (set_flag_i) begin
            flag_q <= 1'b1;
        end else if (clr_flag) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ce_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en_i) begin
            ce_q  <= wr_data_i[BIT_CE];
            sel_q <= {wr_data_i[BIT_SEL3], wr_data_i[2:0]};
        end
    end

    assign flag_o = flag_q;
    assign ce_o   = ce_q;
    assign sel_o  = sel_q;

endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2    = 11,
    parameter bit RST_ENA_INIT = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       kick_i,
    input  logic       gie_i,
    input  logic       ack_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic       irq_o,
    output logic       sys_rst_o,
    output logic [7:0] rd_data_o
);
    wdog_mode_e       mode;
    logic             tmo;
    logic             set_flag;
    logic             flag;
    logic             ce;
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic             re;

    assign ie = (mode == MODE_INT) || (mode == MODE_BOTH);
    assign re = (mode == MODE_RST) || (mode == MODE_BOTH);

    wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (mode != MODE_OFF),
        .kick_i (kick_i),
        .sel_i  (sel),
        .tmo_o  (tmo)
    );

    wdog_fsm #(.RST_ENA_INIT(RST_ENA_INIT)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_ie_i    (wr_data_i[BIT_IE]),
        .wr_re_i    (wr_data_i[BIT_RE]),
        .ack_i      (ack_i),
        .tmo_i      (tmo),
        .flag_i     (flag),
        .state_o    (mode),
        .set_flag_o (set_flag),
        .sys_rst_o  (sys_rst_o)
    );

    wdog_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .ack_i      (ack_i),
        .set_flag_i (set_flag),
        .flag_o     (flag),
        .ce_o       (ce),
        .sel_o      (sel)
    );

    assign irq_o     = flag && ie && gie_i;
    assign rd_data_o = {flag, ie, sel[3], ce, re, sel[2:0]};

endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       kick_i,
    input logic       gie_i,
    input logic       ack_i,
    input logic       wr_en_i,
    input logic       irq_o,
    input logic       sys_rst_o,
    input logic [7:0] rd_data_o
);
    p_irq_needs_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> gie_i);

    p_rst_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |=> !sys_rst_o);

    p_int_mode_no_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[6] && !rd_data_o[3]) |=> !sys_rst_o);

    p_off_no_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_data_o[6] && !rd_data_o[3]) |=> !sys_rst_o);

    p_kick_no_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> !sys_rst_o);

    p_ack_demotes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !wr_en_i && rd_data_o[6] && rd_data_o[3]) |=> (!rd_data_o[6] && rd_data_o[3]));

endmodule

bind wdog_ctl wdog_ctl_chk u_wdog_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (kick_i),
    .gie_i     (gie_i),
    .ack_i     (ack_i),
    .wr_en_i   (wr_en_i),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .rd_data_o (rd_data_o)
);

// File: tb/wdog_ctl_bench.sv
`timescale 1ns/1ps
module wdog_ctl_bench;
    localparam int BASE = 4;
    localparam int L0   = 1 << BASE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kick = 1'b0;
    logic       gie = 1'b1;
    logic       ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq;
    logic       sys_rst;
    logic [7:0] rd;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wdog_ctl #(.BASE_LOG2(BASE), .RST_ENA_INIT(1'b1)) u_wdog_ctl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .kick_i    (kick),
        .gie_i     (gie),
        .ack_i     (ack),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .irq_o     (irq),
        .sys_rst_o (sys_rst),
        .rd_data_o (rd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Stop, clear the flag, then load the mode; the counter starts from zero at the last edge
    task automatic cfg(input logic [7:0] d);
        wr(8'h80); wr(8'h80); wr(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset value", rd, 8'h08);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        idle(L0 - 1);
        chk("R5 no early reset", {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk("R5 reset on time-out", {7'd0, sys_rst}, 8'h01);
        idle(1);
        chk("R5 one-cycle pulse", {7'd0, sys_rst}, 8'h00);
    endtask

    task automatic t_int_mode();
        cfg(8'h40);
        idle(L0 - 1);
        chk("R2 flag not yet set", rd, 8'h40);
        idle(1);
        chk("R3 flag set", rd, 8'hC0);
        chk("R3 no reset", {7'd0, sys_rst}, 8'h00);
        chk("R4 irq with gie", {7'd0, irq}, 8'h01);
        gie = 1'b0; #1;
        chk("R4 irq masked by gie", {7'd0, irq}, 8'h00);
        gie = 1'b1;
        wr(8'h40);
        chk("R8 write 0 keeps flag", rd, 8'hC0);
        wr(8'hC0);
        chk("R8 write 1 clears flag", rd, 8'h40);
    endtask

    task automatic t_period(input logic [7:0] d, input int len, input string tag);
        cfg(d);
        chk({tag, " register readback"}, rd, d);
        idle(len - 1);
        chk({tag, " no early reset"}, {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk({tag, " reset at length"}, {7'd0, sys_rst}, 8'h01);
    endtask

    task automatic t_both_ack();
        cfg(8'h48);
        idle(L0);
        chk("R6 first time-out flags", rd, 8'hC8);
        chk("R6 first time-out no reset", {7'd0, sys_rst}, 8'h00);
        pulse_ack();
        chk("R7 ack clears flag and enable", rd, 8'h08);
        chk("R7 irq dropped", {7'd0, irq}, 8'h00);
        idle(L0 - 2);
        chk("R7 no early reset", {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk("R7 reset after demotion", {7'd0, sys_rst}, 8'h01);
    endtask

    task automatic t_both_rearm();
        cfg(8'h48);
        idle(L0);
        pulse_ack();
        wr(8'h48);
        idle(L0 - 3);
        chk("R11 no reset before", {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk("R11 rearmed: no reset", {7'd0, sys_rst}, 8'h00);
        chk("R11 rearmed: flag again", rd, 8'hC8);
    endtask

    task automatic t_both_noack();
        cfg(8'h48);
        idle(L0);
        chk("R6 flag pending", rd, 8'hC8);
        idle(L0 - 1);
        chk("R6 no early reset", {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk("R6 unacked time-out resets", {7'd0, sys_rst}, 8'h01);
        chk("R6 flag kept", rd, 8'hC8);
    endtask

    task automatic t_kick();
        cfg(8'h08);
        idle(L0 - 2);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        chk("R9 registers unchanged", rd, 8'h08);
        idle(L0 - 1);
        chk("R9 no reset after restart", {7'd0, sys_rst}, 8'h00);
        idle(1);
        chk("R9 reset one period after restart", {7'd0, sys_rst}, 8'h01);
    endtask

    task automatic t_off();
        logic seen;
        cfg(8'h00);
        seen = 1'b0;
        for (int i = 0; i < 3 * L0; i++) begin
            @(negedge clk);
            if (sys_rst || irq || rd[7]) seen = 1'b1;
        end
        chk("R10 off mode quiet", {7'd0, seen}, 8'h00);
        chk("R10 off readback", rd, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_int_mode();
        t_period(8'h09, 2 * L0, "R2 code1");
        t_period(8'h3C, 1 << (BASE + 9), "R2 clamp R1");
        t_both_ack();
        t_both_rearm();
        t_both_noack();
        t_kick();
        t_off();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule